// File: doc/BRIEF.md
# Read Disturb Recovery Classifier

After a page has failed error correction, this block attempts to recover it. It uses the way each marginal cell reacts when it is disturbed on purpose. A single uncorrectable-error pulse starts the sequence. The block first asks the surrounding system to back up the valid contents of the affected block and waits for the acknowledge. It then takes in one quantized threshold value per cell, issues a fixed number of extra disturb reads to the page, and takes in a second threshold value per cell.

Each 2-bit cell state is produced while the second set of values streams in. A cell whose first threshold sits close to one of the three read references is a marginal cell. Such a cell is placed in the upper neighbouring state if its threshold climbed by at least a programmed amount during the disturbance, because a large climb marks a disturb-prone cell. Otherwise it is placed in the lower neighbouring state, as a disturb-resistant cell. Every other cell is decoded from its first threshold alone. The resulting state stream goes on to the error-correction stage, which deals with whatever errors remain.

Top module: `rdr_classifier`

## Requirements
- R1: A sequence starts only when `err_trig_i` is high while the block is idle. `backup_req_o` goes high in the cycle after that trigger.
- R2: `backup_req_o` stays high until `backup_ack_i` is seen. No sense request and no disturb read is issued before that acknowledge.
- R3: Exactly `DISTURB_READS` disturb-read cycles (`disturb_rd_o` high) are issued. `disturb_done_o` is high for one cycle, together with the last of them.
- R4: `sense_req_o` is high with `sense_post_o` low while `N_CELLS` pre-disturb values are taken. It is low during the disturb phase. It is high with `sense_post_o` high while post-disturb values are taken.
- R5: A cell outside every window gets the state equal to the number of references its pre-disturb value is greater than or equal to. The encoding is 0 = erased, 1 = first programmed level, 2 = second, 3 = third. The default references are 64, 128 and 192.
- R6: A cell is a candidate at reference k (k = 0, 1, 2) when ref_k − sigma_k ≤ pre < ref_k + sigma_k. With the default sigma of 8, this is 56..71, 120..135 and 184..199. The shift is post − pre, taken as 0 when post < pre. If the shift is at least the captured threshold, the cell gets state k+1.
- R7: A candidate cell at reference k whose shift is below the captured threshold gets state k.
- R8: For each post-disturb value accepted, `out_valid_o` and `out_state_o` appear one cycle later, in cell order. `class_done_o` is high together with the last cell's output.
- R9: A trigger that arrives while a sequence is in progress is ignored. It does not start another backup request.
- R10: `shift_thr_i` is sampled with the accepted trigger. Later changes to it do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_trig_i | input | 1 | Uncorrectable-error indication for the page |
| shift_thr_i | input | VTH_W | Minimum shift that marks a cell as disturb-prone |
| backup_req_o | output | 1 | Request to back up the block's valid data |
| backup_ack_i | input | 1 | Backup finished |
| sense_req_o | output | 1 | Request for a stream of threshold values |
| sense_post_o | output | 1 | High when the requested stream is post-disturb |
| vth_valid_i | input | 1 | A threshold value is presented |
| vth_i | input | VTH_W | Quantized threshold value of the current cell |
| disturb_rd_o | output | 1 | Issue one disturb read this cycle |
| disturb_done_o | output | 1 | Last disturb read |
| out_valid_o | output | 1 | Output state is valid |
| out_state_o | output | 2 | Recovered cell state |
| class_done_o | output | 1 | Last cell classified |

## Verification
The bench places cells exactly on the edges of each window: 56, 71 and 199 lie inside a window, and 200 lies outside. A design with an off-by-one window would decode such a cell plainly, or would reassign a cell it should leave alone. It also uses a shift equal to the threshold, where a strict comparison would choose the lower state. It also uses a threshold that falls below its pre value, where an unsigned wrap would look like a huge shift and push the cell up. The bench counts every disturb read, so a counter that is one short or one long shows up. A trigger pulsed mid-sequence and a threshold changed after the trigger expose a design that restarts the sequence or reads the threshold live.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BACKUP,
    PH_PRE,
    PH_DIST,
    PH_POST
  } rdr_phase_e;

  localparam int CELL_STATE_W = 2;
  localparam int NUM_REFS     = (1 << CELL_STATE_W) - 1;

  typedef logic [CELL_STATE_W-1:0] cell_state_t;
endpackage

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
  import rdr_pkg::*;
#(
  parameter int VTH_W         = 8,
  parameter int N_CELLS       = 8,
  parameter int DISTURB_READS = 100000,
  localparam int IDX_W        = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
  localparam int CNT_W        = $clog2(DISTURB_READS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_trig_i,
  input  logic [VTH_W-1:0] shift_thr_i,
  input  logic             backup_ack_i,
  input  logic             vth_valid_i,
  output logic             backup_req_o,
  output logic             sense_req_o,
  output logic             sense_post_o,
  output logic             disturb_rd_o,
  output logic             disturb_done_o,
  output logic             pre_we_o,
  output logic             post_vld_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VTH_W-1:0] thr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CELLS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DISTURB_READS - 1);

  rdr_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VTH_W-1:0] thr_q, thr_d;
  logic             thr_en;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    thr_d   = thr_q;
    thr_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (err_trig_i) begin
        phase_d = PH_BACKUP;
        thr_d   = shift_thr_i;
        thr_en  = 1'b1;
      end
      PH_BACKUP: if (backup_ack_i) begin
        phase_d = PH_PRE;
        idx_d   = '0;
      end
      PH_PRE: if (vth_valid_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          phase_d = PH_DIST;
          idx_d   = '0;
          cnt_d   = '0;
        end
      end
      PH_DIST: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) phase_d = PH_POST;
      end
      PH_POST: if (vth_valid_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          phase_d = PH_IDLE;
          idx_d   = '0;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      thr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  assign backup_req_o   = (phase_q == PH_BACKUP);
  assign sense_req_o    = (phase_q == PH_PRE) || (phase_q == PH_POST);
  assign sense_post_o   = (phase_q == PH_POST);
  assign disturb_rd_o   = (phase_q == PH_DIST);
  assign disturb_done_o = (phase_q == PH_DIST) && (cnt_q == LAST_CNT);
  assign pre_we_o       = (phase_q == PH_PRE) && vth_valid_i;
  assign post_vld_o     = (phase_q == PH_POST) && vth_valid_i;
  assign last_o         = post_vld_o && (idx_q == LAST_IDX);
  assign idx_o          = idx_q;
  assign thr_o          = thr_q;

  // Independent tally of disturb reads since the last backup request.
  int unsigned chk_rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            chk_rd_cnt <= 0;
    else if (backup_req_o) chk_rd_cnt <= 0;
    else if (disturb_rd_o) chk_rd_cnt <= chk_rd_cnt + 1;
  end

  p_trig_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_req_o) |-> $past(err_trig_i));

  p_backup_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    backup_req_o && !backup_ack_i |=> backup_req_o);

  p_read_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disturb_done_o |-> (chk_rd_cnt + 1 == DISTURB_READS));

  p_quiet_disturb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disturb_rd_o |-> !sense_req_o && !backup_req_o);
endmodule

// File: rtl/rdr_pre_store.sv
module rdr_pre_store #(
  parameter int VTH_W   = 8,
  parameter int N_CELLS = 8,
  localparam int IDX_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VTH_W-1:0] wdata_i,
  output logic [VTH_W-1:0] rdata_o
);
  logic [VTH_W-1:0] mem_q [N_CELLS];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/rdr_cell_class.sv
module rdr_cell_class
  import rdr_pkg::*;
#(
  parameter int VTH_W = 8,
  parameter logic [NUM_REFS*VTH_W-1:0] VREF  = {8'd192, 8'd128, 8'd64},
  parameter logic [NUM_REFS*VTH_W-1:0] SIGMA = {8'd8, 8'd8, 8'd8}
) (
  input  logic [VTH_W-1:0] pre_i,
  input  logic [VTH_W-1:0] post_i,
  input  logic [VTH_W-1:0] thr_i,
  output cell_state_t      state_o
);
  logic [NUM_REFS-1:0] at_or_above;
  logic [NUM_REFS-1:0] in_win;
  logic signed [VTH_W+1:0] pre_s;
  logic [VTH_W-1:0]        shift;
  logic                    prone;

  assign pre_s = $signed({2'b00, pre_i});
  assign shift = (post_i > pre_i) ? (post_i - pre_i) : '0;
  assign prone = (shift >= thr_i);

  for (genvar k = 0; k < NUM_REFS; k++) begin : g_ref
    localparam logic signed [VTH_W+1:0] REF_S = $signed({2'b00, VREF[k*VTH_W +: VTH_W]});
    localparam logic signed [VTH_W+1:0] SIG_S = $signed({2'b00, SIGMA[k*VTH_W +: VTH_W]});
    assign at_or_above[k] = (pre_s >= REF_S);
    assign in_win[k]      = (pre_s >= REF_S - SIG_S) && (pre_s < REF_S + SIG_S);
  end

  always_comb begin
    state_o = CELL_STATE_W'($countones(at_or_above));
    for (int k = NUM_REFS - 1; k >= 0; k--) begin
      if (in_win[k]) state_o = prone ? CELL_STATE_W'(k + 1) : CELL_STATE_W'(k);
    end
  end
endmodule

// File: rtl/rdr_classifier.sv
module rdr_classifier
  import rdr_pkg::*;
#(
  parameter int VTH_W         = 8,
  parameter int N_CELLS       = 8,
  parameter int DISTURB_READS = 100000,
  parameter logic [NUM_REFS*VTH_W-1:0] VREF  = {8'd192, 8'd128, 8'd64},
  parameter logic [NUM_REFS*VTH_W-1:0] SIGMA = {8'd8, 8'd8, 8'd8}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_trig_i,
  input  logic [VTH_W-1:0] shift_thr_i,
  output logic             backup_req_o,
  input  logic             backup_ack_i,
  output logic             sense_req_o,
  output logic             sense_post_o,
  input  logic             vth_valid_i,
  input  logic [VTH_W-1:0] vth_i,
  output logic             disturb_rd_o,
  output logic             disturb_done_o,
  output logic             out_valid_o,
  output logic [1:0]       out_state_o,
  output logic             class_done_o
);
  localparam int IDX_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;

  logic             pre_we, post_vld, last;
  logic [IDX_W-1:0] idx;
  logic [VTH_W-1:0] thr, pre_val;
  cell_state_t      cls_state;

  logic        out_valid_q, out_valid_d;
  cell_state_t out_state_q;
  logic        done_q, done_d;

  rdr_ctrl #(
    .VTH_W(VTH_W), .N_CELLS(N_CELLS), .DISTURB_READS(DISTURB_READS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .err_trig_i(err_trig_i), .shift_thr_i(shift_thr_i),
    .backup_ack_i(backup_ack_i), .vth_valid_i(vth_valid_i),
    .backup_req_o(backup_req_o), .sense_req_o(sense_req_o), .sense_post_o(sense_post_o),
    .disturb_rd_o(disturb_rd_o), .disturb_done_o(disturb_done_o),
    .pre_we_o(pre_we), .post_vld_o(post_vld), .last_o(last), .idx_o(idx), .thr_o(thr)
  );

  rdr_pre_store #(.VTH_W(VTH_W), .N_CELLS(N_CELLS)) store_i (
    .clk(clk), .we_i(pre_we), .idx_i(idx), .wdata_i(vth_i), .rdata_o(pre_val)
  );

  rdr_cell_class #(.VTH_W(VTH_W), .VREF(VREF), .SIGMA(SIGMA)) class_i (
    .pre_i(pre_val), .post_i(vth_i), .thr_i(thr), .state_o(cls_state)
  );

  always_comb begin
    out_valid_d = post_vld;
    done_d      = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_state_q <= '0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      done_q      <= done_d;
      if (post_vld) out_state_q <= cls_state;
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_state_o  = out_state_q;
  assign class_done_o = done_q;

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    class_done_o |-> out_valid_o);

  p_no_out_unsensed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(sense_post_o && vth_valid_i));
endmodule

// File: tb/rdr_classifier_tb_top.sv
module rdr_classifier_tb_top;
  localparam int VTH_W = 8;
  localparam int NC    = 8;
  localparam int NRD   = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic err_trig, backup_ack, vth_valid;
  logic [VTH_W-1:0] shift_thr, vth;
  logic backup_req, sense_req, sense_post, disturb_rd, disturb_done;
  logic out_valid, class_done;
  logic [1:0] out_state;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rdr_classifier #(.VTH_W(VTH_W), .N_CELLS(NC), .DISTURB_READS(NRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .err_trig_i(err_trig), .shift_thr_i(shift_thr),
    .backup_req_o(backup_req), .backup_ack_i(backup_ack),
    .sense_req_o(sense_req), .sense_post_o(sense_post),
    .vth_valid_i(vth_valid), .vth_i(vth),
    .disturb_rd_o(disturb_rd), .disturb_done_o(disturb_done),
    .out_valid_o(out_valid), .out_state_o(out_state), .class_done_o(class_done)
  );

  // pre, post, expected state at threshold 10, expected at threshold 20, requirement
  // R5: plain decode, R6: prone candidate, R7: resistant candidate
  localparam int TBL [NC][5] = '{
    '{ 20,  40, 0, 0, 5},
    '{100, 100, 1, 1, 5},
    '{ 71,  86, 1, 0, 6},
    '{ 56,  61, 0, 0, 7},
    '{130, 140, 2, 1, 6},
    '{125, 134, 1, 1, 7},
    '{199, 190, 2, 2, 6},
    '{200, 250, 3, 3, 5}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_seq(input int thr, input int col, input int ack_dly, input int thr_late);
    int nrd, ndone, guard;
    @(posedge clk); #1 err_trig = 1'b1; shift_thr = VTH_W'(thr);
    @(posedge clk); #1 err_trig = 1'b0; shift_thr = VTH_W'(thr_late);
    chk("R1 backup_req after trigger", int'(backup_req), 1);
    for (int d = 0; d < ack_dly; d++) begin
      @(posedge clk); #1;
      chk("R2 backup_req held", int'(backup_req), 1);
      chk("R2 no sense before ack", int'(sense_req), 0);
      chk("R2 no disturb before ack", int'(disturb_rd), 0);
    end
    backup_ack = 1'b1;
    @(posedge clk); #1 backup_ack = 1'b0;
    chk("R4 pre sense_req", int'(sense_req), 1);
    chk("R4 pre sense_post", int'(sense_post), 0);
    for (int i = 0; i < NC; i++) begin
      vth_valid = 1'b1; vth = VTH_W'(TBL[i][0]);
      @(posedge clk); #1;
    end
    vth_valid = 1'b0;
    nrd = 0; ndone = 0; guard = 0;
    while (!sense_req && guard < 1000) begin
      chk("R4 no sense during disturb", int'(sense_req), 0);
      if (disturb_rd) nrd++;
      if (disturb_done) ndone++;
      err_trig = (nrd == 5); // R9: trigger mid-sequence
      @(posedge clk); #1;
      guard++;
    end
    err_trig = 1'b0;
    chk("R3 disturb read count", nrd, NRD);
    chk("R3 disturb_done pulses", ndone, 1);
    chk("R4 post sense_post", int'(sense_post), 1);
    for (int i = 0; i < NC; i++) begin
      vth_valid = 1'b1; vth = VTH_W'(TBL[i][1]);
      @(posedge clk); #1 vth_valid = 1'b0;
      chk("R8 out_valid", int'(out_valid), 1);
      chk($sformatf("R%0d cell %0d state (thr %0d)", TBL[i][4], i, thr), int'(out_state), TBL[i][col]);
      chk("R8 class_done", int'(class_done), (i == NC - 1) ? 1 : 0);
    end
    @(posedge clk); #1;
    chk("R8 out_valid drops", int'(out_valid), 0);
    for (int d = 0; d < 5; d++) begin
      chk("R9 no restart from ignored trigger", int'(backup_req), 0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; err_trig = 1'b0; backup_ack = 1'b0; vth_valid = 1'b0;
    shift_thr = '0; vth = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset backup_req", int'(backup_req), 0);
    chk("R4 reset sense_req", int'(sense_req), 0);
    chk("R3 reset disturb_rd", int'(disturb_rd), 0);
    chk("R8 reset out_valid", int'(out_valid), 0);
    // R1: an acknowledge or sample without a trigger starts nothing
    @(posedge clk); #1 backup_ack = 1'b1; vth_valid = 1'b1;
    @(posedge clk); #1 backup_ack = 1'b0; vth_valid = 1'b0;
    chk("R1 no start without trigger", int'(backup_req), 0);
    chk("R1 no sense without trigger", int'(sense_req), 0);
    chk("R8 no output without trigger", int'(out_valid), 0);
    run_seq(10, 2, 3, 10);
    // R10: threshold changed right after trigger must not apply
    run_seq(20, 3, 0, 10);
    summary();
    $finish;
  end
endmodule